// File: doc/BRIEF.md
# AHCI Port Command-Issue Tracker

This block keeps the two per-port slot vectors of an AHCI host port: the command-issue vector, which shows the slots software has handed to the port and that the port has not yet released, and the SATA-active vector, which shows the native-queued commands still outstanding at the device. Software sets bits in both vectors. The command engine reports device-to-host register status for a slot, and also set-device-bits completions that carry a mask of finished queued slots. From these reports the block decides which bits retire, which stay set, and which interrupt status to raise.

The bits retire at different points for the two command types. A queued command frees its issue bit once it has been accepted without error, and that status update raises no interrupt. A non-queued command frees its issue bit on successful completion. A command that ends with the error bit set keeps its issue bit, so the handler can find the failing slot, and it raises the task-file-error interrupt instead of the regular one. Clearing the start bit wipes both vectors. A port reset or a software reset clears only the issue vector.

A two-state sequencer, with states SEQ_IDLE and SEQ_POST, holds every interrupt request back by one cycle. The slot vectors therefore change one clock edge before the matching status bit appears. The sequencer takes the transition IDLE→POST when any request arrives. It takes POST→POST when a further request arrives in the same cycle it posts one, and POST→IDLE when no new request arrives.

Top module: `cmd_issue_tracker`

## Requirements
- R1: After reset, the issue vector, active vector, start bit, interrupt status and interrupt enables are all zero, and both interrupt outputs are low.
- R2: A software write to the issue vector or to the active vector sets each bit that is 1 in the written data. Bits written as 0 keep their value.
- R3: A register status report for a queued command (d2h_ncq=1) whose error, busy and data-request flags are all clear clears that slot's issue bit and sets no interrupt status, whatever the interrupt flag says.
- R4: A register status report for a non-queued command whose error, busy and data-request flags are all clear clears that slot's issue bit. If the report's interrupt flag is set, it sets status bit 0 (regular completion).
- R5: A status report with busy or data-request set and error clear leaves the issue vector and interrupt status unchanged.
- R6: A status report with error set leaves the issue vector unchanged and sets status bit 1 (task-file error), whether or not its interrupt flag is set. It never sets status bit 0.
- R7: A set-device-bits completion clears the active bits named in its mask and leaves all other active bits alone, even when it carries an error. Without error it sets status bit 0 if its interrupt flag is set. With error it sets status bit 1 and not bit 0.
- R8: A write of 0 to the start bit while it is 1 clears both the issue vector and the active vector. A write that leaves the start bit at the same value clears neither.
- R9: A port reset or a software reset clears the issue vector and leaves the active vector unchanged.
- R10: Writing 1 to a status bit clears it, but a set posted in the same cycle wins. Each interrupt output equals its status bit ANDed with its enable bit (bit 0 drives irq_done_o, bit 1 drives irq_tfe_o).
- R11: An interrupt status bit caused by an event becomes visible one cycle after the event's slot-vector update, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ci_set_wr | input | 1 | Software write strobe for the issue vector |
| ci_set_data | input | NSLOT | Bits to set in the issue vector |
| sact_set_wr | input | 1 | Software write strobe for the active vector |
| sact_set_data | input | NSLOT | Bits to set in the active vector |
| st_wr | input | 1 | Software write strobe for the start bit |
| st_data | input | 1 | New start bit value |
| ie_wr | input | 1 | Software write strobe for the interrupt enables |
| ie_data | input | 2 | New enables, bit 0 regular, bit 1 task-file error |
| sts_clr_wr | input | 1 | Software write-one-to-clear strobe for the interrupt status |
| sts_clr_data | input | 2 | Status bits to clear |
| d2h_valid | input | 1 | Register status report for one slot |
| d2h_slot | input | $clog2(NSLOT) | Slot that the report concerns |
| d2h_ncq | input | 1 | Report belongs to a queued command |
| d2h_err | input | 1 | Error flag of the report |
| d2h_bsy | input | 1 | Busy flag of the report |
| d2h_drq | input | 1 | Data-request flag of the report |
| d2h_ibit | input | 1 | Interrupt flag of the report |
| sdb_valid | input | 1 | Set-device-bits completion |
| sdb_done | input | NSLOT | Queued slots finished by this completion |
| sdb_err | input | 1 | Completion carries an error |
| sdb_ibit | input | 1 | Interrupt flag of the completion |
| port_reset | input | 1 | Port (link) reset pulse |
| soft_reset | input | 1 | Software device reset pulse |
| ci_o | output | NSLOT | Issue vector |
| sact_o | output | NSLOT | Active vector |
| st_o | output | 1 | Start bit |
| int_sts_o | output | 2 | Interrupt status, bit 0 regular, bit 1 task-file error |
| irq_done_o | output | 1 | Regular interrupt request |
| irq_tfe_o | output | 1 | Task-file-error interrupt request |

## Verification
The bench uses the default of 32 slots, so the report walk reaches both edge slots, 0 and 31, of the 5-bit slot index. It also covers set-device-bits masks that straddle the upper half of the vector. Each report starts from a fully set issue vector, which makes any clear of a wrong slot visible across all 32 bits. Each report is checked in two steps: the issue vector in the update cycle, then the interrupt status one cycle later. This ordering check is only meaningful because the sequencer is one cycle deep.

// File: rtl/cit_pkg.sv
package cit_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_POST = 1'b1
    } seq_e;

    localparam int IRQ_W    = 2;
    localparam int IRQ_DONE = 0;
    localparam int IRQ_TFE  = 1;
endpackage

// File: rtl/cit_slot_vec.sv
module cit_slot_vec #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         zero_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_q;

    // zeroing beats clearing, clearing beats setting
    always_ff @(posedge clk) begin
        if (!rst_n)      q_q <= '0;
        else if (zero_i) q_q <= '0;
        else             q_q <= (q_q | set_i) & ~clr_i;
    end

    assign q_o = q_q;
endmodule

// File: rtl/cit_irq_ctrl.sv
module cit_irq_ctrl
    import cit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] req_i,
    input  logic             w1c_wr_i,
    input  logic [IRQ_W-1:0] w1c_i,
    input  logic             ie_wr_i,
    input  logic [IRQ_W-1:0] ie_i,
    output logic [IRQ_W-1:0] sts_o,
    output logic [IRQ_W-1:0] irq_o
);
    seq_e             seq_q, seq_d;
    logic [IRQ_W-1:0] pend_q;
    logic [IRQ_W-1:0] sts_q, sts_d;
    logic [IRQ_W-1:0] ie_q;

    // state register and the registers that follow it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= SEQ_IDLE;
            pend_q <= '0;
            sts_q  <= '0;
            ie_q   <= '0;
        end else begin
            seq_q  <= seq_d;
            pend_q <= req_i;
            sts_q  <= sts_d;
            if (ie_wr_i) ie_q <= ie_i;
        end
    end

    // next state
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SEQ_IDLE: if (|req_i) seq_d = SEQ_POST;
            SEQ_POST: seq_d = (|req_i) ? SEQ_POST : SEQ_IDLE;
            default:  seq_d = SEQ_IDLE;
        endcase
    end

    // outputs: clear first, then a posted request wins
    always_comb begin
        sts_d = sts_q;
        if (w1c_wr_i) sts_d = sts_d & ~w1c_i;
        unique case (seq_q)
            SEQ_POST: sts_d = sts_d | pend_q;
            SEQ_IDLE: sts_d = sts_d;
            default:  sts_d = sts_d;
        endcase
    end

    assign sts_o = sts_q;
    assign irq_o = sts_q & ie_q;
endmodule

// File: rtl/cmd_issue_tracker.sv
module cmd_issue_tracker
    import cit_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ci_set_wr,
    input  logic [NSLOT-1:0] ci_set_data,
    input  logic             sact_set_wr,
    input  logic [NSLOT-1:0] sact_set_data,
    input  logic             st_wr,
    input  logic             st_data,
    input  logic             ie_wr,
    input  logic [1:0]       ie_data,
    input  logic             sts_clr_wr,
    input  logic [1:0]       sts_clr_data,
    input  logic             d2h_valid,
    input  logic [SW-1:0]    d2h_slot,
    input  logic             d2h_ncq,
    input  logic             d2h_err,
    input  logic             d2h_bsy,
    input  logic             d2h_drq,
    input  logic             d2h_ibit,
    input  logic             sdb_valid,
    input  logic [NSLOT-1:0] sdb_done,
    input  logic             sdb_err,
    input  logic             sdb_ibit,
    input  logic             port_reset,
    input  logic             soft_reset,
    output logic [NSLOT-1:0] ci_o,
    output logic [NSLOT-1:0] sact_o,
    output logic             st_o,
    output logic [1:0]       int_sts_o,
    output logic             irq_done_o,
    output logic             irq_tfe_o
);
    logic             st_q;
    logic             st_fall;
    logic             d2h_clean;
    logic [NSLOT-1:0] slot_1h;
    logic [NSLOT-1:0] ci_set, ci_clr, sact_set, sact_clr;
    logic             ci_zero;
    logic [IRQ_W-1:0] irq_req;
    logic [IRQ_W-1:0] irq_vec;

    always_ff @(posedge clk) begin
        if (!rst_n)     st_q <= 1'b0;
        else if (st_wr) st_q <= st_data;
    end

    assign st_fall   = st_wr & ~st_data & st_q;
    assign d2h_clean = d2h_valid & ~d2h_err & ~d2h_bsy & ~d2h_drq;
    assign slot_1h   = {{(NSLOT-1){1'b0}}, 1'b1} << d2h_slot;

    assign ci_set   = ci_set_wr   ? ci_set_data   : '0;
    assign sact_set = sact_set_wr ? sact_set_data : '0;
    assign ci_clr   = d2h_clean   ? slot_1h       : '0;
    assign sact_clr = sdb_valid   ? sdb_done      : '0;
    assign ci_zero  = st_fall | port_reset | soft_reset;

    assign irq_req[IRQ_DONE] = (d2h_clean & ~d2h_ncq & d2h_ibit)
                             | (sdb_valid & ~sdb_err & sdb_ibit);
    assign irq_req[IRQ_TFE]  = (d2h_valid & d2h_err) | (sdb_valid & sdb_err);

    cit_slot_vec #(.W(NSLOT)) u_ci (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ci_set),
        .clr_i  (ci_clr),
        .zero_i (ci_zero),
        .q_o    (ci_o)
    );

    cit_slot_vec #(.W(NSLOT)) u_sact (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sact_set),
        .clr_i  (sact_clr),
        .zero_i (st_fall),
        .q_o    (sact_o)
    );

    cit_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (irq_req),
        .w1c_wr_i (sts_clr_wr),
        .w1c_i    (sts_clr_data),
        .ie_wr_i  (ie_wr),
        .ie_i     (ie_data),
        .sts_o    (int_sts_o),
        .irq_o    (irq_vec)
    );

    assign st_o       = st_q;
    assign irq_done_o = irq_vec[IRQ_DONE];
    assign irq_tfe_o  = irq_vec[IRQ_TFE];
endmodule

// File: rtl/cmd_issue_tracker_chk.sv
module cmd_issue_tracker_chk #(
    parameter int NSLOT = 32,
    localparam int SW   = $clog2(NSLOT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sact_set_wr,
    input logic             st_wr,
    input logic             st_data,
    input logic             d2h_valid,
    input logic [SW-1:0]    d2h_slot,
    input logic             d2h_err,
    input logic             d2h_bsy,
    input logic             d2h_drq,
    input logic             sdb_valid,
    input logic             port_reset,
    input logic             soft_reset,
    input logic [NSLOT-1:0] ci_o,
    input logic [NSLOT-1:0] sact_o,
    input logic             st_o,
    input logic [1:0]       int_sts_o
);
    // R6: a failing slot keeps its issue bit
    assert_err_keeps_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (d2h_valid && d2h_err && ci_o[d2h_slot] && !port_reset && !soft_reset
         && !(st_wr && !st_data && st_o))
        |=> ci_o[$past(d2h_slot)]);

    // R6: task-file error status follows an error report after the posting cycle
    assert_err_raises_tfe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (d2h_valid && d2h_err) |=> ##1 int_sts_o[1]);

    // R9: either reset empties the issue vector
    assert_reset_clears_ci_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (port_reset || soft_reset) |=> (ci_o == '0));

    // R9: resets leave the active vector alone
    assert_reset_keeps_sact_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_reset || soft_reset) && !sact_set_wr && !sdb_valid
         && !(st_wr && !st_data && st_o))
        |=> $stable(sact_o));

    // R8: stopping the port empties both vectors
    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !st_data && st_o) |=> (ci_o == '0 && sact_o == '0));

    // R11: a clean report has retired its slot by the next cycle
    assert_clean_retires_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (d2h_valid && !d2h_err && !d2h_bsy && !d2h_drq) |=> !ci_o[$past(d2h_slot)]);
endmodule

bind cmd_issue_tracker cmd_issue_tracker_chk #(.NSLOT(NSLOT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sact_set_wr (sact_set_wr),
    .st_wr       (st_wr),
    .st_data     (st_data),
    .d2h_valid   (d2h_valid),
    .d2h_slot    (d2h_slot),
    .d2h_err     (d2h_err),
    .d2h_bsy     (d2h_bsy),
    .d2h_drq     (d2h_drq),
    .sdb_valid   (sdb_valid),
    .port_reset  (port_reset),
    .soft_reset  (soft_reset),
    .ci_o        (ci_o),
    .sact_o      (sact_o),
    .st_o        (st_o),
    .int_sts_o   (int_sts_o)
);

// File: tb/sim_cmd_issue_tracker.sv
module sim_cmd_issue_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 32;
    localparam int SW = $clog2(NSLOT);
    localparam logic [NSLOT-1:0] ALL1 = '1;

    // entry: slot[12:8] ncq[7] err[6] bsy[5] drq[4] ibit[3] exp_clr[2] exp_reg[1] exp_tfe[0]
    localparam int NVEC = 8;
    localparam logic [12:0] VEC [NVEC] = '{
        {5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {5'd31, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {5'd5,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {5'd7,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {5'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {5'd10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {5'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {5'd20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ci_set_wr = 0, sact_set_wr = 0, st_wr = 0, st_data = 0;
    logic ie_wr = 0, sts_clr_wr = 0;
    logic [1:0] ie_data = '0, sts_clr_data = '0;
    logic [NSLOT-1:0] ci_set_data = '0, sact_set_data = '0, sdb_done = '0;
    logic d2h_valid = 0, d2h_ncq = 0, d2h_err = 0, d2h_bsy = 0, d2h_drq = 0, d2h_ibit = 0;
    logic [SW-1:0] d2h_slot = '0;
    logic sdb_valid = 0, sdb_err = 0, sdb_ibit = 0, port_reset = 0, soft_reset = 0;
    logic [NSLOT-1:0] ci_o, sact_o;
    logic st_o, irq_done_o, irq_tfe_o;
    logic [1:0] int_sts_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_issue_tracker #(.NSLOT(NSLOT)) u0 (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ci(input logic [NSLOT-1:0] v);
        ci_set_wr = 1; ci_set_data = v; step(); ci_set_wr = 0; ci_set_data = '0;
    endtask

    task automatic set_sact(input logic [NSLOT-1:0] v);
        sact_set_wr = 1; sact_set_data = v; step(); sact_set_wr = 0; sact_set_data = '0;
    endtask

    task automatic wr_st(input logic v);
        st_wr = 1; st_data = v; step(); st_wr = 0; st_data = 0;
    endtask

    task automatic clr_sts();
        sts_clr_wr = 1; sts_clr_data = 2'b11; step(); sts_clr_wr = 0; sts_clr_data = '0;
        step();
    endtask

    task automatic sdb(input logic [NSLOT-1:0] m, input logic e, input logic ib);
        sdb_valid = 1; sdb_done = m; sdb_err = e; sdb_ibit = ib; step();
        sdb_valid = 0; sdb_done = '0; sdb_err = 0; sdb_ibit = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R1: reset state
        check("R1 ci", ci_o, '0);
        check("R1 sact", sact_o, '0);
        check("R1 st", st_o, 0);
        check("R1 sts", int_sts_o, 2'b00);
        check("R1 irq", {irq_done_o, irq_tfe_o}, 2'b00);
        rst_n = 1;
        step();
        wr_st(1);
        ie_wr = 1; ie_data = 2'b11; step(); ie_wr = 0;

        // table walk: R3 R4 R5 R6 R11
        for (int i = 0; i < NVEC; i++) begin
            logic [NSLOT-1:0] exp_ci;
            clr_sts();
            set_ci(ALL1);
            d2h_valid = 1;
            d2h_slot = VEC[i][12:8]; d2h_ncq = VEC[i][7]; d2h_err = VEC[i][6];
            d2h_bsy = VEC[i][5]; d2h_drq = VEC[i][4]; d2h_ibit = VEC[i][3];
            exp_ci = ALL1;
            if (VEC[i][2]) exp_ci[VEC[i][12:8]] = 1'b0;
            step();
            d2h_valid = 0; d2h_ncq = 0; d2h_err = 0; d2h_bsy = 0; d2h_drq = 0; d2h_ibit = 0;
            check($sformatf("R3/R4/R5/R6 ci vec%0d", i), ci_o, exp_ci);
            check($sformatf("R11 sts late vec%0d", i), int_sts_o, 2'b00);
            step();
            check($sformatf("R4/R6 sts vec%0d", i), int_sts_o, {VEC[i][0], VEC[i][1]});
            check($sformatf("R10 irq vec%0d", i), {irq_tfe_o, irq_done_o}, {VEC[i][0], VEC[i][1]});
        end

        // R2: writes only set bits
        wr_st(0);
        check("R8 stop ci", ci_o, '0);
        check("R8 stop sact", sact_o, '0);
        wr_st(1);
        set_ci(32'h0000_00F0);
        set_ci(32'h0000_0000);
        check("R2 ci", ci_o, 32'h0000_00F0);
        set_sact(32'h0F0F_0000);
        set_sact(32'h0000_0001);
        check("R2 sact", sact_o, 32'h0F0F_0001);

        // R8: rewriting same start value does not clear
        wr_st(1);
        check("R8 same st ci", ci_o, 32'h0000_00F0);
        check("R8 same st sact", sact_o, 32'h0F0F_0001);

        // R9: resets clear issue only
        port_reset = 1; step(); port_reset = 0;
        check("R9 port ci", ci_o, '0);
        check("R9 port sact", sact_o, 32'h0F0F_0001);
        set_ci(32'h8000_0003);
        soft_reset = 1; step(); soft_reset = 0;
        check("R9 soft ci", ci_o, '0);
        check("R9 soft sact", sact_o, 32'h0F0F_0001);

        // R7: set-device-bits completions
        clr_sts();
        sdb(32'h0001_0001, 0, 1);
        check("R7 sact mask", sact_o, 32'h0F0E_0000);
        step();
        check("R7 sts ok", int_sts_o, 2'b01);
        clr_sts();
        sdb(32'h0100_0000, 1, 1);
        check("R7 sact err", sact_o, 32'h0E0E_0000);
        step();
        check("R7 sts err", int_sts_o, 2'b10);

        // R10: enable masking and write-one-to-clear
        ie_wr = 1; ie_data = 2'b01; step(); ie_wr = 0;
        check("R10 mask tfe", {irq_tfe_o, irq_done_o}, 2'b00);
        sts_clr_wr = 1; sts_clr_data = 2'b10; step(); sts_clr_wr = 0;
        check("R10 w1c", int_sts_o, 2'b00);
        // R10: set beats clear in the posting cycle
        d2h_valid = 1; d2h_err = 1; d2h_slot = 5'd3; step();
        d2h_valid = 0; d2h_err = 0;
        sts_clr_wr = 1; sts_clr_data = 2'b10; step(); sts_clr_wr = 0;
        check("R10 set wins", int_sts_o, 2'b10);

        // R8: stop with start already 0 keeps vectors
        wr_st(0);
        set_ci(32'h0000_0100);
        wr_st(0);
        check("R8 idle stop ci", ci_o, 32'h0000_0100);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule